// File: doc/BRIEF.md
# Reloadable Baud Rate Generator

This block is a down-counting timer on the system clock that emits a one-cycle tick each time it wraps through zero. A serial port uses the tick as its bit-rate or oversampling clock. Counting happens only while the run input is high, and the counter holds its value while run is low.

One register location does two jobs. A read returns the live counter value. A write stores a new reload value and also restarts the counter from that value.

If the timer is stopped when the write arrives, the counter is not touched at once. The restart waits for the first clock edge on which run is high again. On that edge the restart replaces counting, and it produces no tick.

Top module: `baud_reload_gen`

## Requirements
- R1: Synchronous active-high reset clears the counter, the stored reload value and any pending restart, and holds the tick low.
- R2: While run is 0 and no write occurs, the counter keeps its value and the tick stays low.
- R3: While run is 1 and the counter is non-zero (no write, no pending restart), each clock decrements the counter by one with the tick low.
- R4: While run is 1 and the counter is 0 (no write, no pending restart), the next clock raises the tick for exactly one cycle and loads the counter from the stored reload value. A reload value N therefore gives one tick every N+1 running clocks.
- R5: The read data output always shows the live counter value, never the stored reload value.
- R6: A write while run is 1 stores the value and loads it into the counter on the same edge. The tick stays low on that edge, even when the counter was 0.
- R7: A write while run is 0 stores the value and leaves the counter unchanged. On the first clock edge with run equal to 1, the counter loads the stored value and the tick stays low.
- R8: Several writes while stopped leave only the last written value to be loaded when run returns.
- R9: With a reload value of 0 and run held at 1, the tick is high on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Counter enable |
| wr_en_i | input | 1 | Write strobe for the reload register |
| wr_data_i | input | CNT_W | New reload value |
| rd_data_o | output | CNT_W | Live counter value |
| tick_o | output | 1 | One-cycle pulse on each wrap through zero |

## Verification
The bench goes after the following corner cases:

- **Write on the wrap cycle.** A write that lands while the counter is at zero with run high must restart the counter without a tick. A design that gives the wrap priority would pulse and load the old reload value.
- **Writes while stopped.** Writes that arrive while the timer is stopped must leave the visible count frozen. A design that loads at once would show the new value too early. One that forgets the pending restart would resume counting down from the stale value.
- **Period and reload of zero.** The period is checked as N+1 clocks. With a reload of 0 the tick must stay high on every running clock. An off-by-one in the wrap test would stretch or shorten each period.

// File: rtl/baud_reload_pkg.sv
package baud_reload_pkg;

  // What the counter does on the next clock edge.
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_DEC  = 2'd2,
    OP_WRAP = 2'd3
  } cnt_op_e;

endpackage

// File: rtl/baud_reload_store.sv
module baud_reload_store #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] reload_o,
  output logic             pend_o
);

  logic [CNT_W-1:0] reload_q;
  logic             pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (wr_en_i) begin
        reload_q <= wr_data_i;
      end
      // A write while stopped arms the deferred restart.
      // The first running edge then consumes it.
      if (wr_en_i) begin
        pend_q <= ~run_i;
      end else if (run_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign reload_o = reload_q;
  assign pend_o   = pend_q;

endmodule

// File: rtl/baud_op_sel.sv
module baud_op_sel
  import baud_reload_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             run_i,
  input  logic             wr_en_i,
  input  logic             pend_i,
  input  logic [CNT_W-1:0] count_i,
  output cnt_op_e          op_o
);

  // Priority: a running write, then a pending restart, then wrap or decrement.
  always_comb begin
    op_o = OP_HOLD;
    if (run_i) begin
      if (wr_en_i || pend_i) begin
        op_o = OP_LOAD;
      end else if (count_i == '0) begin
        op_o = OP_WRAP;
      end else begin
        op_o = OP_DEC;
      end
    end
  end

endmodule

// File: rtl/baud_down_counter.sv
module baud_down_counter
  import baud_reload_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_op_e          op_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tick_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic             tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      tick_q  <= 1'b0;
    end else begin
      tick_q <= (op_i == OP_WRAP);
      case (op_i)
        OP_LOAD, OP_WRAP: count_q <= load_val_i;
        OP_DEC:           count_q <= count_q - ONE;
        default:          count_q <= count_q;
      endcase
    end
  end

  assign count_o = count_q;
  assign tick_o  = tick_q;

endmodule

// File: rtl/baud_reload_gen.sv
module baud_reload_gen
  import baud_reload_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             tick_o
);

  logic [CNT_W-1:0] reload_w;
  logic             pend_w;
  logic [CNT_W-1:0] count_w;
  logic [CNT_W-1:0] load_val_w;
  cnt_op_e          op_w;

  baud_reload_store #(.CNT_W(CNT_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .run_i    (run_i),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .reload_o (reload_w),
    .pend_o   (pend_w)
  );

  baud_op_sel #(.CNT_W(CNT_W)) u_sel (
    .run_i  (run_i),
    .wr_en_i(wr_en_i),
    .pend_i (pend_w),
    .count_i(count_w),
    .op_o   (op_w)
  );

  // A write on this edge bypasses the register that has not caught it yet.
  assign load_val_w = wr_en_i ? wr_data_i : reload_w;

  baud_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op_w),
    .load_val_i(load_val_w),
    .count_o   (count_w),
    .tick_o    (tick_o)
  );

  assign rd_data_o = count_w;

endmodule

// File: rtl/baud_reload_gen_chk.sv
module baud_reload_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run_i,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] rd_data_o,
  input logic             tick_o,
  input logic [CNT_W-1:0] reload_w,
  input logic             pend_w
);

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !wr_en_i) |=> ($stable(rd_data_o) && !tick_o));

  a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
    (run_i && !wr_en_i && !pend_w && rd_data_o != '0)
      |=> (rd_data_o == CNT_W'($past(rd_data_o) - 1'b1) && !tick_o));

  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (run_i && !wr_en_i && !pend_w && rd_data_o == '0)
      |=> (tick_o && rd_data_o == $past(reload_w)));

  a_r6_run_write: assert property (@(posedge clk) disable iff (rst)
    (run_i && wr_en_i) |=> (rd_data_o == $past(wr_data_i) && !tick_o && !pend_w));

  a_r7_arm: assert property (@(posedge clk) disable iff (rst)
    (!run_i && wr_en_i) |=> (pend_w && reload_w == $past(wr_data_i)));

  a_r7_apply: assert property (@(posedge clk) disable iff (rst)
    (run_i && !wr_en_i && pend_w) |=> (rd_data_o == $past(reload_w) && !tick_o && !pend_w));

endmodule

bind baud_reload_gen baud_reload_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .run_i    (run_i),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o),
  .tick_o   (tick_o),
  .reload_w (reload_w),
  .pend_w   (pend_w)
);

// File: tb/baud_reload_gen_bench.sv
module baud_reload_gen_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         run;
  logic         we;
  logic [W-1:0] wd;
  logic [W-1:0] rd;
  logic         tick;

  int checks = 0;
  int errors = 0;

  // Reference state, built from the requirements.
  logic [W-1:0] m_reload;
  logic [W-1:0] m_count;
  logic         m_pend;
  logic         m_tick;
  string        m_tag;

  always #5 clk = ~clk;

  baud_reload_gen #(.CNT_W(W)) u_baud_reload_gen (
    .clk(clk), .rst(rst), .run_i(run), .wr_en_i(we),
    .wr_data_i(wd), .rd_data_o(rd), .tick_o(tick)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model_step(logic r, logic w, logic [W-1:0] d);
    m_tick = 1'b0;
    if (w) begin
      m_reload = d;
      if (r) begin
        m_count = d; m_pend = 1'b0; m_tag = "R6";
      end else begin
        m_pend = 1'b1; m_tag = "R7";
      end
    end else if (!r) begin
      m_tag = "R2";
    end else if (m_pend) begin
      m_count = m_reload; m_pend = 1'b0; m_tag = "R7";
    end else if (m_count == '0) begin
      m_count = m_reload; m_tick = 1'b1; m_tag = "R4";
    end else begin
      m_count = m_count - 1'b1; m_tag = "R3";
    end
  endfunction

  // Drive the inputs for one edge, then compare after the edge settles.
  task automatic cyc(logic r, logic w, logic [W-1:0] d);
    run = r; we = w; wd = d;
    @(posedge clk);
    #1;
    model_step(r, w, d);
    check({m_tag, " count (R5 live read)"}, rd, m_count);
    check({m_tag, " tick"}, {{(W-1){1'b0}}, tick}, {{(W-1){1'b0}}, m_tick});
    #3;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int ticks;
    void'($urandom(32'd4242));
    rst = 1'b1; run = 1'b1; we = 1'b1; wd = 16'h1234;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset count", rd, '0);
    check("R1 reset tick", {{(W-1){1'b0}}, tick}, '0);
    m_reload = '0; m_count = '0; m_pend = 1'b0; m_tick = 1'b0;
    #3;
    rst = 1'b0;

    // R9: a reload of 0 after reset ticks on every running clock.
    for (int i = 0; i < 4; i++) begin
      cyc(1'b1, 1'b0, '0);
      check("R9 tick every clock", {{(W-1){1'b0}}, tick}, {{(W-1){1'b0}}, 1'b1});
    end

    // R4: a reload of 5 gives a period of 6 clocks.
    cyc(1'b1, 1'b1, 16'd5);
    ticks = 0;
    for (int i = 0; i < 18; i++) begin
      cyc(1'b1, 1'b0, '0);
      ticks += int'(tick);
    end
    check("R4 ticks in 18 clocks at N=5", W'(ticks), W'(3));

    // R6: a write landing on the wrap cycle restarts the counter with no tick.
    while (rd != '0) cyc(1'b1, 1'b0, '0);
    cyc(1'b1, 1'b1, 16'd9);
    check("R6 load beats wrap", rd, 16'd9);

    // R7 and R8: two writes while stopped; the count holds, then loads the last value.
    cyc(1'b0, 1'b1, 16'd100);
    check("R7 count held after stopped write", rd, 16'd9);
    cyc(1'b0, 1'b1, 16'd200);
    cyc(1'b0, 1'b0, '0);
    check("R2 held while stopped", rd, 16'd9);
    cyc(1'b1, 1'b0, '0);
    check("R8 last written value loaded", rd, 16'd200);
    cyc(1'b1, 1'b0, '0);
    check("R3 decrement after deferred load", rd, 16'd199);

    // Random stimulus against the reference state.
    for (int i = 0; i < 4000; i++) begin
      logic r, w;
      r = ($urandom_range(0, 9) < 7);
      w = ($urandom_range(0, 19) == 0);
      cyc(r, w, W'($urandom_range(0, 12)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule